// File: doc/BRIEF.md
# Fixed-Latency Delayed-Writeback Issue Stage

This block is the issue and writeback core of a wide-instruction machine. Each clock cycle it takes one instruction made of several operation slots. Each slot names a source register, a destination register, an operation and an assumed latency. Every slot reads its operands from a shared register file in the issue cycle. The slot then computes a result and holds it in a delay line until the stated number of cycles has passed. At that point the result is written to the register file, no sooner and no later.

The block has no interlocks and never stalls. Whatever sits in a destination register stays readable by later instructions until the pending result lands. The compiler can therefore schedule around the assumed latencies and reuse a register while its new value is still in flight. Sometimes two results land on one register at the same clock edge. A fixed priority then picks the winner, and a sticky flag records that it happened. A combinational debug port reads any register at any time.

Top module: `twb_issue`

## Requirements
- R1: When reset is released, register i holds the value i and `wb_collision` is 0.
- R2: The 2-bit operation field selects the result. 0 gives the copy R[src]. 1 gives R[src]+R[dst]. 2 gives R[src]^R[dst]. 3 gives R[src]+1. Arithmetic wraps at 32 bits.
- R3: A slot issued in cycle t with latency L (1..7) leaves its destination unchanged through cycle t+L-1. The new value is first visible in cycle t+L.
- R4: A latency field of 0 behaves exactly like a latency of 1.
- R5: Both operands (R[src] and R[dst]) are sampled only in the issue cycle. Later writes to those registers do not change a result that is still pending.
- R6: All slots of one instruction read before any write lands. A read in the cycle that a write to the same register lands returns the older value, so two same-instruction copies that target each other's source swap the values.
- R7: A slot whose valid bit is 0 never writes any register, whatever its other fields hold.
- R8: When several results land on one register at the same edge, the higher-numbered slot wins. Within one slot, the later-issued result (the one with the shorter latency) wins. `wb_collision` goes to 1 in the following cycle and stays 1 until reset.
- R9: Results that land on different registers at the same edge all commit, and `wb_collision` does not change.
- R10: `dbg_data` shows the current contents of register `dbg_addr` combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | NSLOT | Per-slot valid bits |
| slot_op | input | 2*NSLOT | Per-slot operation fields, slot s at bits [2s+1:2s] |
| slot_src | input | NSLOT*RIDX | Per-slot source register index |
| slot_dst | input | NSLOT*RIDX | Per-slot destination register index |
| slot_lat | input | NSLOT*LATW | Per-slot assumed latency in cycles |
| dbg_addr | input | RIDX | Debug read address |
| dbg_data | output | DW | Debug read data |
| wb_collision | output | 1 | Sticky flag: two results landed on one register at the same edge |

## Verification
Two events can fall in the same cycle on one register. One is a delayed result landing. The other is a new instruction sampling that register as an operand, or a second result landing on it. The bench provokes both by issuing with staggered latencies so that the landing edge matches the read cycle, or so that two results meet at one edge. A reference model keeps a queue of pending writes indexed by landing cycle and ordered by slot and issue time. Every register is compared with this model through the debug port in every cycle, so the bench checks that the read returned the old value and that the right result won.

// File: rtl/twb_pkg.sv
package twb_pkg;

  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_ADD  = 2'd1,
    OP_XOR  = 2'd2,
    OP_INC  = 2'd3
  } twb_op_e;

endpackage

// File: rtl/twb_slot_exec.sv
module twb_slot_exec #(
  parameter int DW   = 32,
  parameter int LATW = 3
) (
  input  logic [1:0]      op,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [LATW-1:0] lat_raw,
  output logic [DW-1:0]   result,
  output logic [LATW-1:0] lat_eff
);
  import twb_pkg::*;

  twb_op_e op_e;
  assign op_e = twb_op_e'(op);

  always_comb begin
    unique case (op_e)
      OP_COPY: result = opa;
      OP_ADD:  result = opa + opb;
      OP_XOR:  result = opa ^ opb;
      OP_INC:  result = opa + DW'(1);
      default: result = opa;
    endcase
  end

  // zero latency is folded onto the unit-latency path
  always_comb begin
    if (lat_raw == '0) lat_eff = LATW'(1);
    else               lat_eff = lat_raw;
  end

endmodule

// File: rtl/twb_delay_line.sv
module twb_delay_line #(
  parameter int DEPTH = 1,
  parameter int RIDX  = 4,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [RIDX-1:0] in_dst,
  input  logic [DW-1:0]   in_dat,
  output logic            out_vld,
  output logic [RIDX-1:0] out_dst,
  output logic [DW-1:0]   out_dat
);

  generate
    if (DEPTH == 0) begin : g_bypass
      assign out_vld = in_vld;
      assign out_dst = in_dst;
      assign out_dat = in_dat;
    end else begin : g_pipe
      logic [DEPTH-1:0] vld_q;
      logic [DEPTH-1:0] vld_d;
      logic [RIDX-1:0]  dst_q [DEPTH];
      logic [RIDX-1:0]  dst_d [DEPTH];
      logic [DW-1:0]    dat_q [DEPTH];
      logic [DW-1:0]    dat_d [DEPTH];

      always_comb begin
        vld_d[DEPTH-1] = in_vld;
        dst_d[DEPTH-1] = in_dst;
        dat_d[DEPTH-1] = in_dat;
        for (int k = 0; k < DEPTH-1; k++) begin
          vld_d[k] = vld_q[k+1];
          dst_d[k] = dst_q[k+1];
          dat_d[k] = dat_q[k+1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
      end

      // payload loads only when a live entry moves in
      always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
          if (vld_d[k]) begin
            dst_q[k] <= dst_d[k];
            dat_q[k] <= dat_d[k];
          end
        end
      end

      assign out_vld = vld_q[0];
      assign out_dst = dst_q[0];
      assign out_dat = dat_q[0];
    end
  endgenerate

endmodule

// File: rtl/twb_regfile.sv
module twb_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int NWR  = 14,
  parameter int NRD  = 5,
  parameter int RIDX = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NWR-1:0]            wr_vld,
  input  logic [NWR-1:0][RIDX-1:0]  wr_dst,
  input  logic [NWR-1:0][DW-1:0]    wr_dat,
  input  logic [NRD-1:0][RIDX-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]    rd_dat,
  output logic                      coll_now
);

  logic [DW-1:0]   mem_q [NREG];
  logic [DW-1:0]   mem_d [NREG];
  logic [NREG-1:0] wen;

  // writers are walked from lowest to highest priority: last one wins
  always_comb begin
    wen      = '0;
    coll_now = 1'b0;
    for (int r = 0; r < NREG; r++) mem_d[r] = mem_q[r];
    for (int w = 0; w < NWR; w++) begin
      if (wr_vld[w]) begin
        if (wen[wr_dst[w]]) coll_now = 1'b1;
        wen[wr_dst[w]]   = 1'b1;
        mem_d[wr_dst[w]] = wr_dat[w];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) mem_q[r] <= DW'(r);
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wen[r]) mem_q[r] <= mem_d[r];
      end
    end
  end

  genvar i;
  generate
    for (i = 0; i < NRD; i++) begin : g_rd
      assign rd_dat[i] = mem_q[rd_addr[i]];
    end
  endgenerate

endmodule

// File: rtl/twb_issue.sv
module twb_issue #(
  parameter int NSLOT = 2,
  parameter int NREG  = 16,
  parameter int DW    = 32,
  parameter int LATW  = 3,
  parameter int RIDX  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSLOT-1:0]        slot_vld,
  input  logic [2*NSLOT-1:0]      slot_op,
  input  logic [NSLOT*RIDX-1:0]   slot_src,
  input  logic [NSLOT*RIDX-1:0]   slot_dst,
  input  logic [NSLOT*LATW-1:0]   slot_lat,
  input  logic [RIDX-1:0]         dbg_addr,
  output logic [DW-1:0]           dbg_data,
  output logic                    wb_collision
);

  localparam int MAXLAT = (1 << LATW) - 1;
  localparam int NWR    = NSLOT * MAXLAT;
  localparam int NRD    = 2 * NSLOT + 1;
  localparam int DBGP   = 2 * NSLOT;

  logic [NWR-1:0]            wr_vld;
  logic [NWR-1:0][RIDX-1:0]  wr_dst;
  logic [NWR-1:0][DW-1:0]    wr_dat;
  logic [NRD-1:0][RIDX-1:0]  rd_addr;
  logic [NRD-1:0][DW-1:0]    rd_dat;
  logic                      coll_now;
  logic                      coll_q;
  logic                      coll_d;

  assign rd_addr[DBGP] = dbg_addr;
  assign dbg_data      = rd_dat[DBGP];

  genvar s, l;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      logic [DW-1:0]   res;
      logic [LATW-1:0] lat_eff;
      logic [RIDX-1:0] dst;

      assign rd_addr[2*s]   = slot_src[s*RIDX +: RIDX];
      assign rd_addr[2*s+1] = slot_dst[s*RIDX +: RIDX];
      assign dst            = slot_dst[s*RIDX +: RIDX];

      twb_slot_exec #(.DW(DW), .LATW(LATW)) u_exec (
        .op      (slot_op[2*s +: 2]),
        .opa     (rd_dat[2*s]),
        .opb     (rd_dat[2*s+1]),
        .lat_raw (slot_lat[s*LATW +: LATW]),
        .result  (res),
        .lat_eff (lat_eff)
      );

      // one line per latency value; writer rank grows with slot and recency
      for (l = 1; l <= MAXLAT; l++) begin : g_lat
        localparam int WIDX = s * MAXLAT + (MAXLAT - l);
        logic take;
        assign take = slot_vld[s] && (lat_eff == LATW'(l));

        twb_delay_line #(.DEPTH(l - 1), .RIDX(RIDX), .DW(DW)) u_line (
          .clk     (clk),
          .rst_n   (rst_n),
          .in_vld  (take),
          .in_dst  (dst),
          .in_dat  (res),
          .out_vld (wr_vld[WIDX]),
          .out_dst (wr_dst[WIDX]),
          .out_dat (wr_dat[WIDX])
        );
      end
    end
  endgenerate

  twb_regfile #(
    .NREG(NREG), .DW(DW), .NWR(NWR), .NRD(NRD), .RIDX(RIDX)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_vld   (wr_vld),
    .wr_dst   (wr_dst),
    .wr_dat   (wr_dat),
    .rd_addr  (rd_addr),
    .rd_dat   (rd_dat),
    .coll_now (coll_now)
  );

  always_comb coll_d = coll_q | coll_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coll_q <= 1'b0;
    else        coll_q <= coll_d;
  end

  assign wb_collision = coll_q;

endmodule

// File: rtl/twb_checker.sv
module twb_checker #(
  parameter int NSLOT  = 2,
  parameter int NWR    = 14,
  parameter int RIDX   = 4,
  parameter int DW     = 32,
  parameter int MAXLAT = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSLOT-1:0] slot_vld,
  input logic [NWR-1:0]  wr_vld,
  input logic            coll_now,
  input logic            wb_collision,
  input logic [RIDX-1:0] dbg_addr,
  input logic [DW-1:0]   dbg_data
);

  localparam int CW = $clog2(MAXLAT + 1);

  logic [CW-1:0] idle_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         idle_run <= '0;
    else if (slot_vld != '0)            idle_run <= '0;
    else if (idle_run != CW'(MAXLAT))   idle_run <= idle_run + CW'(1);
  end

  // R7: a long enough run of empty instructions leaves nothing to land
  a_r7_idle_no_land: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld == '0 && idle_run >= CW'(MAXLAT - 1)) |-> (wr_vld == '0));

  // R8: the collision flag never clears on its own
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wb_collision |=> wb_collision);

  // R8: the flag rises only after a same-register landing
  a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_collision) |-> $past(coll_now));

  // R9: without a same-register landing the flag stays low
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!coll_now && !wb_collision) |=> !wb_collision);

  // R10: with no landing and a fixed address the debug value holds
  a_r10_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(dbg_addr) && $past(wr_vld) == '0) |-> $stable(dbg_data));

endmodule

bind twb_issue twb_checker #(
  .NSLOT(NSLOT), .NWR(NWR), .RIDX(RIDX), .DW(DW), .MAXLAT(MAXLAT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slot_vld     (slot_vld),
  .wr_vld       (wr_vld),
  .coll_now     (coll_now),
  .wb_collision (wb_collision),
  .dbg_addr     (dbg_addr),
  .dbg_data     (dbg_data)
);

// File: tb/tb_twb_issue.sv
`timescale 1ns/1ps
module tb_twb_issue;

  localparam int NS = 2;
  localparam int NR = 16;
  localparam int RI = 4;
  localparam int ML = 7;
  localparam int NW = NS * ML;

  logic           clk;
  logic           rst_n;
  logic [NS-1:0]  slot_vld;
  logic [2*NS-1:0] slot_op;
  logic [NS*RI-1:0] slot_src;
  logic [NS*RI-1:0] slot_dst;
  logic [NS*3-1:0]  slot_lat;
  logic [RI-1:0]  dbg_addr;
  logic [31:0]    dbg_data;
  logic           wb_collision;

  twb_issue dut (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_op(slot_op),
    .slot_src(slot_src), .slot_dst(slot_dst), .slot_lat(slot_lat),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .wb_collision(wb_collision)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  string cur_req = "R1";

  // stimulus for the next cycle
  bit        iv   [NS];
  bit [1:0]  iop  [NS];
  bit [3:0]  isrc [NS];
  bit [3:0]  idst [NS];
  bit [2:0]  ilat [NS];

  // reference model: register image and landing queue
  logic [31:0] refm [NR];
  bit          bv   [8][NW];
  bit [3:0]    bdst [8][NW];
  logic [31:0] bdat [8][NW];
  bit          mflag;
  int          cyc;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check_val(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_reg(input int a, input logic [31:0] exp, input string req);
    dbg_addr = 4'(a);
    #0.25;
    check_val(req, $sformatf("reg %0d", a), dbg_data, exp);
  endtask

  task automatic sweep_model();
    for (int r = 0; r < NR; r++) begin
      dbg_addr = 4'(r);
      #0.25;
      check_val(cur_req, $sformatf("model reg %0d", r), dbg_data, refm[r]);
    end
    check_val(cur_req, "collision flag", {31'd0, wb_collision}, {31'd0, mflag});
  endtask

  function automatic logic [31:0] model_op(input bit [1:0] op,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
    case (op)
      2'd0: return a;
      2'd1: return a + b;
      2'd2: return a ^ b;
      default: return a + 32'd1;
    endcase
  endfunction

  task automatic clear_in();
    for (int s = 0; s < NS; s++) begin
      iv[s] = 0; iop[s] = 0; isrc[s] = 0; idst[s] = 0; ilat[s] = 0;
    end
  endtask

  // one cycle: drive, compare, model the edge
  task automatic do_cycle();
    bit seen [NR];
    for (int s = 0; s < NS; s++) begin
      slot_vld[s]          = iv[s];
      slot_op[2*s +: 2]    = iop[s];
      slot_src[s*RI +: RI] = isrc[s];
      slot_dst[s*RI +: RI] = idst[s];
      slot_lat[s*3 +: 3]   = ilat[s];
    end
    sweep_model();
    for (int s = 0; s < NS; s++) begin
      if (iv[s]) begin
        int L = (ilat[s] == 0) ? 1 : int'(ilat[s]);
        int w = s * ML + (ML - L);
        int b = (cyc + L - 1) % 8;
        bv[b][w]   = 1;
        bdst[b][w] = idst[s];
        bdat[b][w] = model_op(iop[s], refm[isrc[s]], refm[idst[s]]);
      end
    end
    @(posedge clk);
    for (int r = 0; r < NR; r++) seen[r] = 0;
    for (int w = 0; w < NW; w++) begin
      int b = cyc % 8;
      if (bv[b][w]) begin
        if (seen[bdst[b][w]]) mflag = 1;
        seen[bdst[b][w]] = 1;
        refm[bdst[b][w]] = bdat[b][w];
        bv[b][w] = 0;
      end
    end
    cyc++;
    #2;
    clear_in();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) do_cycle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clear_in();
    slot_vld = '0; slot_op = '0; slot_src = '0; slot_dst = '0; slot_lat = '0;
    dbg_addr = '0;
    for (int r = 0; r < NR; r++) refm[r] = 32'(r);
    for (int b = 0; b < 8; b++)
      for (int w = 0; w < NW; w++) bv[b][w] = 0;
    mflag = 0;
    cyc = 0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic set_slot(input int s, input bit [1:0] op, input int src,
                          input int dst, input int lat);
    iv[s] = 1; iop[s] = op; isrc[s] = 4'(src); idst[s] = 4'(dst); ilat[s] = 3'(lat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();

    // R1: reset image and flag
    cur_req = "R1";
    for (int r = 0; r < NR; r++) check_reg(r, 32'(r), "R1");
    check_val("R1", "flag after reset", {31'd0, wb_collision}, 32'd0);

    // R2: each operation at unit latency
    cur_req = "R2";
    set_slot(0, 2'd1, 2, 1, 1);
    set_slot(1, 2'd2, 6, 5, 1);
    do_cycle();
    set_slot(0, 2'd3, 9, 7, 1);
    set_slot(1, 2'd0, 12, 8, 1);
    do_cycle();
    check_reg(1, 32'd3, "R2");
    check_reg(5, 32'd3, "R2");
    check_reg(7, 32'd10, "R2");
    check_reg(8, 32'd12, "R2");

    // R3: exact landing cycle of a latency-5 copy
    do_reset();
    cur_req = "R3";
    set_slot(0, 2'd0, 15, 10, 5);
    do_cycle();
    for (int k = 1; k <= 4; k++) begin
      check_reg(10, 32'd10, "R3");
      do_cycle();
    end
    check_reg(10, 32'd15, "R3");

    // R4: latency field 0 acts as 1
    cur_req = "R4";
    set_slot(1, 2'd3, 11, 11, 0);
    do_cycle();
    check_reg(11, 32'd12, "R4");

    // R5: operands frozen at issue
    do_reset();
    cur_req = "R5";
    set_slot(0, 2'd1, 13, 12, 4);
    do_cycle();
    set_slot(0, 2'd0, 0, 12, 1);
    set_slot(1, 2'd0, 0, 13, 1);
    do_cycle();
    check_reg(12, 32'd0, "R5");
    idle(2);
    check_reg(12, 32'd25, "R5");
    check_reg(13, 32'd0, "R5");

    // R6: swap in one instruction, and a read in the landing cycle
    do_reset();
    cur_req = "R6";
    set_slot(0, 2'd0, 4, 3, 1);
    set_slot(1, 2'd0, 3, 4, 1);
    do_cycle();
    check_reg(3, 32'd4, "R6");
    check_reg(4, 32'd3, "R6");
    set_slot(0, 2'd0, 14, 6, 2);
    do_cycle();
    set_slot(1, 2'd0, 6, 2, 1);
    do_cycle();
    check_reg(2, 32'd6, "R6");
    check_reg(6, 32'd14, "R6");

    // R7: invalid slots with live-looking fields
    do_reset();
    cur_req = "R7";
    iop[0] = 2'd0; isrc[0] = 4'd0; idst[0] = 4'd9; ilat[0] = 3'd1;
    iop[1] = 2'd3; isrc[1] = 4'd1; idst[1] = 4'd9; ilat[1] = 3'd3;
    do_cycle();
    idle(8);
    check_reg(9, 32'd9, "R7");
    check_val("R7", "flag", {31'd0, wb_collision}, 32'd0);

    // R9: different registers at one edge
    cur_req = "R9";
    set_slot(0, 2'd0, 15, 1, 3);
    set_slot(1, 2'd0, 14, 2, 3);
    do_cycle();
    idle(3);
    check_reg(1, 32'd15, "R9");
    check_reg(2, 32'd14, "R9");
    check_val("R9", "flag", {31'd0, wb_collision}, 32'd0);

    // R8: same register, same edge, across slots
    do_reset();
    cur_req = "R8";
    set_slot(0, 2'd0, 1, 4, 2);
    set_slot(1, 2'd0, 2, 4, 2);
    do_cycle();
    check_val("R8", "flag before landing", {31'd0, wb_collision}, 32'd0);
    do_cycle();
    check_reg(4, 32'd2, "R8");
    check_val("R8", "flag set", {31'd0, wb_collision}, 32'd1);
    idle(5);
    check_val("R8", "flag sticky", {31'd0, wb_collision}, 32'd1);

    // R8: same slot, later issue wins
    do_reset();
    set_slot(0, 2'd0, 1, 7, 3);
    do_cycle();
    set_slot(0, 2'd0, 2, 7, 2);
    do_cycle();
    do_cycle();
    check_reg(7, 32'd2, "R8");
    check_val("R8", "flag same slot", {31'd0, wb_collision}, 32'd1);

    // R8: higher slot beats recency
    do_reset();
    set_slot(1, 2'd0, 1, 7, 3);
    do_cycle();
    set_slot(0, 2'd0, 2, 7, 2);
    do_cycle();
    do_cycle();
    check_reg(7, 32'd1, "R8");

    // R10: debug port follows the address inside one cycle
    cur_req = "R10";
    check_reg(3, 32'd3, "R10");
    check_reg(12, 32'd12, "R10");

    // R3: sweep slot, latency (with 0 for R4) and operation
    do_reset();
    cur_req = "R3";
    for (int s = 0; s < NS; s++)
      for (int L = 0; L < 8; L++)
        for (int op = 0; op < 4; op++) begin
          set_slot(s, 2'(op), (s * 5 + L + op) % 16, (L * 3 + op + s) % 16, L);
          do_cycle();
          idle(8);
        end

    // mixed traffic against the model
    do_reset();
    cur_req = "R8";
    for (int k = 0; k < 2500; k++) begin
      for (int s = 0; s < NS; s++) begin
        if ($urandom_range(0, 3) != 0)
          set_slot(s, 2'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                   int'($urandom_range(0, 15)), int'($urandom_range(0, 7)));
      end
      do_cycle();
    end
    idle(8);

    finish_run();
  end

endmodule